// File: doc/BRIEF.md
# DMA Channel Request and Reload Controller

This block is the control side of one DMA channel; a two-channel system places two copies of it side by side. Software programs it through a small write/read register port. A source register and a destination register hold start addresses. A reload register holds the number of transfers. A control word holds the enable, the pending-request flag, the transfer width and the two direction bits. A select word picks what triggers a transfer.

The trigger is either a software trigger bit or one of the peripheral interrupt-request inputs. A peripheral input is chosen by a 4-bit field and one extra bit above it. A rising edge of the chosen signal sets the pending flag, whether or not the channel is enabled. Every write of 1 to the enable bit loads the working pointer and the remaining-transfer counter. While the channel is enabled and a request is pending, the block clears the flag and sends a one-cycle start strobe to an external transfer sequencer. It then waits for that sequencer's done strobe.

Each done strobe steps the pointer by 1 or 2 and decrements the counter. When the last transfer finishes, the channel disables itself and raises a one-cycle completion pulse. Bus arbitration and the memory cycles themselves sit outside the block, behind the start/done pair.

Top module: `dma_chan_ctrl`

## Requirements
- R1: A write to the control word (address 0) with bit 0 = 1 loads the pointer, and it does so even when the channel is already enabled. The pointer comes from the destination register (address 3) when only bit 4 (destination forward) is set. It comes from the source register (address 2) in every other case: bit 3 (source forward) alone, both bits set, or neither bit set. The pointer reads back at address 5.
- R2: The same enabling write loads the counter (read at address 6) from the reload register (address 4).
- R3: A rising edge of the selected request signal sets the pending flag (control bit 1). It does so whether bit 0 (enable) is 0 or 1.
- R4: While enabled, idle and pending, the next clock edge clears the pending flag and raises xfer_start for exactly one cycle, with xfer_addr equal to the pointer.
- R5: A control write with bit 1 = 0 clears the pending flag. A control write with bit 1 = 1 leaves it unchanged. If a request edge falls in the same cycle as a clearing write, the flag ends up set.
- R6: The select word sits at address 1. Bits 3:0 are the source field, bit 4 is the extra select bit, bit 5 selects software mode and bit 6 is the software trigger. In software mode the request signal is bit 6. Otherwise it is periph_req[{bit 4, bits 3:0}]. Edges on inputs that are not selected have no effect.
- R7: Each xfer_done strobe while busy decrements the counter by 1. It also advances the pointer by 1 when control bit 2 (wide) is 0, or by 2 when bit 2 is 1.
- R8: The done strobe that takes the counter from 1 to 0 clears the enable bit and raises complete for exactly one cycle.
- R9: Between a start strobe and the following done strobe, no further start strobe is issued; a request arriving in that window stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | ADDR_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | ADDR_W | Register read data (combinational) |
| periph_req | input | 2**(SEL_W+1) | Peripheral interrupt-request flags |
| xfer_start | output | 1 | One-cycle start strobe to the transfer sequencer |
| xfer_addr | output | ADDR_W | Working pointer handed with the start strobe |
| xfer_wide | output | 1 | Transfer width: 0 for single, 1 for double |
| xfer_done | input | 1 | Transfer finished strobe from the sequencer |
| complete | output | 1 | One-cycle pulse when the last transfer finishes |

## Verification
The bench builds the block with ADDR_W = 16, CNT_W = 8 and SEL_W = 4, which gives 32 peripheral inputs. Index 17 can therefore be reached only through the extra select bit. A 16-bit pointer makes every direction-bit combination visible in a distinct address. An 8-bit counter with small reload values lets each vector run its whole countdown through to the completion pulse.

// File: rtl/dma_pkg.sv
package dma_pkg;
  // register map (address decode shared by the top and the bench view)
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_SEL  = 3'd1;
  localparam logic [2:0] RA_SRC  = 3'd2;
  localparam logic [2:0] RA_DST  = 3'd3;
  localparam logic [2:0] RA_RLD  = 3'd4;
  localparam logic [2:0] RA_PTR  = 3'd5;
  localparam logic [2:0] RA_CNT  = 3'd6;

  // control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_PEND = 1;
  localparam int CB_WIDE = 2;
  localparam int CB_SFWD = 3;
  localparam int CB_DFWD = 4;

  // reload picks destination only when it alone is forward
  function automatic logic use_dst(logic sfwd, logic dfwd);
    return dfwd & ~sfwd;
  endfunction

  // pointer advance per completed transfer
  function automatic logic [31:0] step_ptr(logic [31:0] p, logic wide);
    return p + (wide ? 32'd2 : 32'd1);
  endfunction
endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel #(
  parameter int SEL_W = 4,
  localparam int NSRC = 2 ** (SEL_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  periph_req,
  input  logic [SEL_W:0]   sel_idx,
  input  logic             sw_mode,
  input  logic             sw_trig,
  output logic             req_edge
);
  logic req_sig;
  logic req_prev;

  assign req_sig  = sw_mode ? sw_trig : periph_req[sel_idx];
  assign req_edge = req_sig & ~req_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_prev <= 1'b0;
    else        req_prev <= req_sig;
  end

  AST_EDGE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) req_edge |=> req_prev); // R6
endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic [ADDR_W-1:0] ld_ptr,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              wide,
  input  logic              go,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] ptr,
  output logic [CNT_W-1:0]  cnt,
  output logic              busy,
  output logic              xfer_start,
  output logic              fin
);
  logic step_ev;

  assign step_ev = busy & xfer_done;
  assign fin     = step_ev & (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr        <= '0;
      cnt        <= '0;
      busy       <= 1'b0;
      xfer_start <= 1'b0;
    end else begin
      xfer_start <= go;
      if (go)           busy <= 1'b1;
      else if (step_ev) busy <= 1'b0;
      if (reload) begin
        ptr <= ld_ptr;
        cnt <= ld_cnt;
      end else if (step_ev) begin
        ptr <= ADDR_W'(step_ptr(32'(ptr), wide));
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) xfer_start |=> !xfer_start); // R4
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (busy && !xfer_done) |=> !xfer_start); // R9
  AST_RELOAD_CNT: assert property (@(posedge clk) disable iff (!rst_n) reload |=> (cnt == $past(ld_cnt))); // R2
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (step_ev && !reload) |=> (cnt == $past(cnt) - CNT_W'(1))); // R7
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int SEL_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [2:0]                wr_addr,
  input  logic [ADDR_W-1:0]         wr_data,
  input  logic [2:0]                rd_addr,
  output logic [ADDR_W-1:0]         rd_data,
  input  logic [2**(SEL_W+1)-1:0]   periph_req,
  output logic                      xfer_start,
  output logic [ADDR_W-1:0]         xfer_addr,
  output logic                      xfer_wide,
  input  logic                      xfer_done,
  output logic                      complete
);
  localparam int SELR_W = SEL_W + 3;

  logic              en, pend, wide, sfwd, dfwd;
  logic [SELR_W-1:0] sel_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  rld_q;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  cnt;
  logic              busy, fin, req_edge, go;
  logic              ctrl_wr, reload, sw_clr;
  logic [ADDR_W-1:0] ld_ptr;

  assign ctrl_wr = wr_en && (wr_addr == RA_CTRL);
  assign reload  = ctrl_wr && wr_data[CB_EN];
  assign sw_clr  = ctrl_wr && !wr_data[CB_PEND];
  assign go      = en && pend && !busy;
  assign ld_ptr  = use_dst(wr_data[CB_SFWD], wr_data[CB_DFWD]) ? dst_q : src_q;

  dma_req_sel #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req),
    .sel_idx(sel_q[SEL_W:0]), .sw_mode(sel_q[SEL_W+1]), .sw_trig(sel_q[SEL_W+2]),
    .req_edge(req_edge)
  );

  dma_xfer_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .reload(reload), .ld_ptr(ld_ptr), .ld_cnt(rld_q),
    .wide(wide), .go(go), .xfer_done(xfer_done), .ptr(ptr), .cnt(cnt),
    .busy(busy), .xfer_start(xfer_start), .fin(fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; pend <= 1'b0; wide <= 1'b0; sfwd <= 1'b0; dfwd <= 1'b0;
      sel_q <= '0; src_q <= '0; dst_q <= '0; rld_q <= '0;
      complete <= 1'b0;
    end else begin
      complete <= fin;
      // pending flag: request set beats both software clear and start clear
      if (req_edge)           pend <= 1'b1;
      else if (go || sw_clr)  pend <= 1'b0;
      if (ctrl_wr) begin
        en   <= wr_data[CB_EN];
        wide <= wr_data[CB_WIDE];
        sfwd <= wr_data[CB_SFWD];
        dfwd <= wr_data[CB_DFWD];
      end else if (fin) begin
        en <= 1'b0;
      end
      if (wr_en) begin
        case (wr_addr)
          RA_SEL: sel_q <= wr_data[SELR_W-1:0];
          RA_SRC: src_q <= wr_data;
          RA_DST: dst_q <= wr_data;
          RA_RLD: rld_q <= wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      RA_CTRL: rd_data = ADDR_W'({dfwd, sfwd, wide, pend, en});
      RA_SEL:  rd_data = ADDR_W'(sel_q);
      RA_SRC:  rd_data = src_q;
      RA_DST:  rd_data = dst_q;
      RA_RLD:  rd_data = ADDR_W'(rld_q);
      RA_PTR:  rd_data = ptr;
      RA_CNT:  rd_data = ADDR_W'(cnt);
      default: rd_data = '0;
    endcase
  end

  assign xfer_addr = ptr;
  assign xfer_wide = wide;

  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n) req_edge |=> pend); // R3
  AST_SW_NO_SET: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_wr && !req_edge && !pend) |=> !pend); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (go && !req_edge) |=> (!pend && xfer_start)); // R4
  AST_FIN_DISABLES: assert property (@(posedge clk) disable iff (!rst_n) (fin && !ctrl_wr) |=> (!en && complete)); // R8
  AST_RELOAD_PTR: assert property (@(posedge clk) disable iff (!rst_n) reload |=> (xfer_addr == $past(ld_ptr))); // R1
endmodule

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int SW = 4;
  localparam int NS = 2 ** (SW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [AW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [AW-1:0] rd_data;
  logic [NS-1:0] periph_req = '0;
  logic          xfer_start;
  logic [AW-1:0] xfer_addr;
  logic          xfer_wide;
  logic          xfer_done = 1'b0;
  logic          complete;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  dma_chan_ctrl #(.ADDR_W(AW), .CNT_W(CW), .SEL_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .periph_req(periph_req),
    .xfer_start(xfer_start), .xfer_addr(xfer_addr), .xfer_wide(xfer_wide),
    .xfer_done(xfer_done), .complete(complete)
  );

  // vector: {sfwd, dfwd, wide, 5'b0, reload[7:0], src[15:0], dst[15:0], first_ptr[15:0]}
  localparam logic [63:0] VEC [4] = '{
    {1'b1, 1'b0, 1'b0, 5'd0, 8'd3, 16'h0040, 16'h0800, 16'h0040},
    {1'b0, 1'b1, 1'b1, 5'd0, 8'd2, 16'h0040, 16'h0800, 16'h0800},
    {1'b1, 1'b1, 1'b1, 5'd0, 8'd1, 16'h1230, 16'h4560, 16'h1230},
    {1'b0, 1'b0, 1'b0, 5'd0, 8'd2, 16'h00FE, 16'h0F00, 16'h00FE}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [2:0] a, input logic [AW-1:0] exp);
    rd_addr = a;
    #1;
    chk(tag, 32'(rd_data), 32'(exp));
  endtask

  task automatic pend_chk(input string tag, input logic exp);
    rd_addr = 3'd0;
    #1;
    chk(tag, 32'(rd_data[1]), 32'(exp));
  endtask

  task automatic sw_req();
    wr(3'd1, 16'h0060);
    wr(3'd1, 16'h0020);
  endtask

  task automatic wait_start(input string tag);
    logic found = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (!found) begin
        if (xfer_start) found = 1'b1;
        else @(negedge clk);
      end
    end
    chk(tag, 32'(found), 32'd1);
  endtask

  task automatic pulse_done();
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic no_start(input string tag, input int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (xfer_start) seen = 1'b1;
    end
    chk(tag, 32'(seen), 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R4 reset start", 32'(xfer_start), 32'd0);
    chk("R8 reset complete", 32'(complete), 32'd0);
    rchk("R1 reset ctrl", 3'd0, 16'h0000);
    rchk("R1 reset ptr", 3'd5, 16'h0000);
    rchk("R2 reset cnt", 3'd6, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // vector walk: reload source choice, counter load, stepping, completion
    wr(3'd1, 16'h0020);
    for (int v = 0; v < 4; v++) begin
      logic s, d, w;
      logic [7:0] rl;
      logic [15:0] sa, da, fp;
      logic [15:0] step;
      {s, d, w} = VEC[v][63:61];
      rl = VEC[v][55:48];
      sa = VEC[v][47:32];
      da = VEC[v][31:16];
      fp = VEC[v][15:0];
      step = w ? 16'd2 : 16'd1;
      wr(3'd2, sa);
      wr(3'd3, da);
      wr(3'd4, 16'(rl));
      wr(3'd0, 16'({d, s, w, 1'b0, 1'b1}));
      rchk($sformatf("R1 vec%0d ptr", v), 3'd5, fp);
      rchk($sformatf("R2 vec%0d cnt", v), 3'd6, 16'(rl));
      for (int k = 0; k < int'(rl); k++) begin
        sw_req();
        wait_start($sformatf("R4 vec%0d start%0d", v, k));
        chk($sformatf("R7 vec%0d addr%0d", v, k), 32'(xfer_addr), 32'(fp + 16'(k) * step));
        chk($sformatf("R7 vec%0d wide%0d", v, k), 32'(xfer_wide), 32'(w));
        pulse_done();
        if (k == int'(rl) - 1) begin
          chk($sformatf("R8 vec%0d complete", v), 32'(complete), 32'd1);
          rchk($sformatf("R8 vec%0d en clear", v), 3'd0, 16'({d, s, w, 1'b0, 1'b0}));
          @(negedge clk);
          chk($sformatf("R8 vec%0d pulse one", v), 32'(complete), 32'd0);
        end else begin
          chk($sformatf("R8 vec%0d no complete", v), 32'(complete), 32'd0);
          rchk($sformatf("R7 vec%0d cnt%0d", v, k), 3'd6, 16'(rl - 8'(k) - 8'd1));
        end
      end
    end

    // R3: peripheral 17 via extra select bit, channel disabled
    wr(3'd1, 16'h0011);
    wr(3'd0, 16'h0000);
    @(negedge clk); periph_req[17] = 1'b1;
    @(negedge clk); @(negedge clk); periph_req[17] = 1'b0;
    pend_chk("R3 pend while disabled", 1'b1);
    no_start("R3 no start while disabled", 3);

    // R5: write of 1 to pending does not set it
    wr(3'd0, 16'h0000);
    pend_chk("R5 cleared by write 0", 1'b0);
    wr(3'd0, 16'h0002);
    pend_chk("R5 write 1 no set", 1'b0);

    // R6: unselected input ignored, selected input counts
    wr(3'd1, 16'h0005);
    wr(3'd0, 16'h0000);
    @(negedge clk); periph_req[6] = 1'b1;
    @(negedge clk); @(negedge clk); periph_req[6] = 1'b0;
    pend_chk("R6 other input ignored", 1'b0);
    @(negedge clk); periph_req[5] = 1'b1;
    @(negedge clk); @(negedge clk); periph_req[5] = 1'b0;
    pend_chk("R6 selected input", 1'b1);

    // R5: request edge coincides with clearing write -> set wins
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0000; periph_req[5] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    pend_chk("R5 set beats clear", 1'b1);
    periph_req[5] = 1'b0;

    // R9: request while busy stays pending, no second start
    wr(3'd1, 16'h0020);
    wr(3'd2, 16'h0200);
    wr(3'd4, 16'h0003);
    wr(3'd0, 16'h0009);
    sw_req();
    wait_start("R4 busy test start");
    chk("R4 busy test addr", 32'(xfer_addr), 32'h0200);
    sw_req();
    no_start("R9 no start while busy", 3);
    pend_chk("R9 pending held", 1'b1);
    pulse_done();
    wait_start("R9 start after done");
    chk("R9 second addr", 32'(xfer_addr), 32'h0201);
    pulse_done();
    rchk("R7 cnt after two", 3'd6, 16'h0001);

    // R1/R2: rewrite enable while enabled reloads
    wr(3'd0, 16'h0009);
    rchk("R1 re-enable ptr", 3'd5, 16'h0200);
    rchk("R2 re-enable cnt", 3'd6, 16'h0003);

    // R5: stale pending cleared in the same write that enables
    wr(3'd0, 16'h0008);
    sw_req();
    pend_chk("R3 pend set disabled", 1'b1);
    wr(3'd0, 16'h0009);
    no_start("R5 enable with clear no start", 4);
    pend_chk("R5 pend cleared on enable", 1'b0);
    rchk("R2 cnt untouched", 3'd6, 16'h0003);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule